// File: doc/BRIEF.md
# Two-Channel DAC Register Update Controller

This block is the register core of a two-channel DAC whose codes arrive over a serial link. Each channel has two registers. The first is a staging register that a completed write fills. The second is an output register whose value goes to the converter. A serial front end, outside this block, decodes bus traffic and presents it as single-cycle strobes. One strobe marks the start of a write. The other marks the ninth clock of the final byte, and it arrives together with a channel select and a 16-bit data field.

Two active-low pins act on the registers from outside the clock domain. The load pin moves new staging data into the output registers. A falling edge on the load pin transfers every channel with a pending update in the same cycle. While the load pin is held low, each write goes straight through to its output register.

A falling edge on the clear pin zeroes every register and drops the pending flags. It also aborts a write that is in flight and enters a clear-code mode. That mode lasts until the next valid write completes. While the clear pin stays low, the load pin has no effect. A clear that arrives while the bus runs at high speed raises a one-cycle request for the front end to leave that speed mode. Both pins pass through two-flop synchronisers, and edges are detected after synchronisation.

Top module: `dac2_regctl`

## Requirements
- R1: After reset, both output codes are zero, the pending flags `pend` are 00 and `clr_mode` is 0.
- R2: A commit with the load pin high writes `wr_data[15 -: DATA_W]` into the staging register of the channel that `wr_chan` selects (0 = A, 1 = B). It sets that channel's pending bit (bit 0 = A, bit 1 = B) and leaves both output codes unchanged.
- R3: A falling edge on the synchronised load pin copies every pending staging register into its output register in the same cycle and clears those pending bits. A channel that is not pending keeps its output code.
- R4: While the load pin is held low and the clear pin is high, a commit updates the selected channel's output code directly and leaves its pending bit clear.
- R5: A falling edge on the synchronised clear pin zeroes all staging and output registers, clears `pend` and sets `clr_mode`.
- R6: While the clear pin is low, load-pin edges and the direct path have no effect, so both output codes hold. A commit made during this time still reaches the staging register and marks it pending.
- R7: A clear edge that arrives after `wr_begin` and before that write's commit discards the commit. The staging registers stay zero and `clr_mode` stays 1.
- R8: `clr_mode` returns to 0 only on a commit that is not discarded.
- R9: A clear edge while `hs_active` is high produces exactly one cycle of `hs_exit`. Without `hs_active`, a clear edge produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ldac_n_pin | input | 1 | Load pin, active low, asynchronous |
| clr_n_pin | input | 1 | Clear pin, active low, falling-edge sensed, asynchronous |
| wr_begin | input | 1 | Strobe: a write sequence has started |
| wr_commit | input | 1 | Strobe: ninth clock of the final byte of a write |
| wr_chan | input | 1 | Channel select for the commit, 0 = A, 1 = B |
| wr_data | input | 16 | Data field of the write, MSB-aligned |
| hs_active | input | 1 | The bus is in high-speed mode |
| dac_a | output | DATA_W | Output register code of channel A |
| dac_b | output | DATA_W | Output register code of channel B |
| pend | output | 2 | Pending-update flags, bit 0 = A, bit 1 = B |
| clr_mode | output | 1 | Clear-code mode is active |
| hs_exit | output | 1 | One-cycle request to leave high-speed mode |

## Verification
The bench builds the block with `DATA_W` set to 12. At that width the lowest four bits of the data field must be dropped, so a write whose low nibble is non-zero shows whether the code is taken from the most significant bits. Random data also reaches the highest and lowest codes. The synchroniser depth stays at its default of 2. This allows pin sequences that cross each other: a load pulse while the clear pin is held low, a write committed during a clear, a clear in the middle of a write, and a load pin held low while writes arrive.

// File: rtl/dac2_pkg.sv
package dac2_pkg;
  localparam int NCH     = 2;
  localparam int FIELD_W = 16;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;
endpackage

// File: rtl/dac2_pin_sync.sv
module dac2_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{IDLE_LV}};
      prev_q <= IDLE_LV;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/dac2_ctl.sv
module dac2_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_fall,
  input  logic clr_lvl,
  input  logic ldac_fall,
  input  logic ldac_lvl,
  input  logic wr_begin,
  input  logic wr_commit,
  input  logic hs_active,
  output logic commit_ok,
  output logic direct_en,
  output logic xfer_en,
  output logic zero_en,
  output logic clr_mode,
  output logic hs_exit
);
  logic in_write_q, in_write_d;
  logic aborted_q, aborted_d;
  logic mode_q, mode_d;
  logic hsx_q, hsx_d;

  // A commit is honoured unless its write was aborted or a clear lands with it.
  assign commit_ok = wr_commit & ~aborted_q & ~clr_fall;
  assign zero_en   = clr_fall;
  assign direct_en = commit_ok & ~ldac_lvl & clr_lvl;
  assign xfer_en   = ldac_fall & clr_lvl & ~clr_fall;

  always_comb begin
    in_write_d = in_write_q;
    if (wr_begin)       in_write_d = 1'b1;
    else if (wr_commit) in_write_d = 1'b0;

    aborted_d = aborted_q;
    if (clr_fall)                    aborted_d = (in_write_q | wr_begin) & ~wr_commit;
    else if (wr_begin || wr_commit)  aborted_d = 1'b0;

    mode_d = mode_q;
    if (clr_fall)       mode_d = 1'b1;
    else if (commit_ok) mode_d = 1'b0;

    hsx_d = clr_fall & hs_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_write_q <= 1'b0;
      aborted_q  <= 1'b0;
      mode_q     <= 1'b0;
      hsx_q      <= 1'b0;
    end else begin
      in_write_q <= in_write_d;
      aborted_q  <= aborted_d;
      mode_q     <= mode_d;
      hsx_q      <= hsx_d;
    end
  end

  assign clr_mode = mode_q;
  assign hs_exit  = hsx_q;
endmodule

// File: rtl/dac2_chan.sv
module dac2_chan #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero_en,
  input  logic         wr_en,
  input  logic         direct_en,
  input  logic         xfer_en,
  input  logic [W-1:0] wr_code,
  output logic [W-1:0] dac_code,
  output logic         pend
);
  logic [W-1:0] in_q, in_d, dac_q, dac_d;
  logic         pend_q, pend_d;

  always_comb begin
    in_d   = in_q;
    dac_d  = dac_q;
    pend_d = pend_q;
    if (zero_en) begin
      in_d   = '0;
      dac_d  = '0;
      pend_d = 1'b0;
    end else begin
      if (wr_en) in_d = wr_code;
      if (wr_en && direct_en) begin
        dac_d  = wr_code;
        pend_d = 1'b0;
      end else if (wr_en) begin
        pend_d = 1'b1;
      end else if (xfer_en && pend_q) begin
        dac_d  = in_q;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      dac_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      in_q   <= in_d;
      dac_q  <= dac_d;
      pend_q <= pend_d;
    end
  end

  assign dac_code = dac_q;
  assign pend     = pend_q;
endmodule

// File: rtl/dac2_regctl.sv
module dac2_regctl
  import dac2_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ldac_n_pin,
  input  logic              clr_n_pin,
  input  logic              wr_begin,
  input  logic              wr_commit,
  input  logic              wr_chan,
  input  logic [15:0]       wr_data,
  input  logic              hs_active,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic [1:0]        pend,
  output logic              clr_mode,
  output logic              hs_exit
);
  localparam int MSB = FIELD_W - 1;

  logic clr_lvl, clr_fall, ldac_lvl, ldac_fall;
  logic commit_ok, direct_en, xfer_en, zero_en;
  logic [DATA_W-1:0] wr_code;
  logic [DATA_W-1:0] code_q [NCH];
  logic [NCH-1:0]    pend_q;

  assign wr_code = wr_data[MSB -: DATA_W];

  dac2_pin_sync #(.STAGES(SYNC_STG), .IDLE_LV(1'b1)) u_clr_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(clr_n_pin), .lvl_o(clr_lvl), .fall_o(clr_fall));

  dac2_pin_sync #(.STAGES(SYNC_STG), .IDLE_LV(1'b1)) u_ldac_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ldac_n_pin), .lvl_o(ldac_lvl), .fall_o(ldac_fall));

  dac2_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .clr_fall(clr_fall), .clr_lvl(clr_lvl),
    .ldac_fall(ldac_fall), .ldac_lvl(ldac_lvl),
    .wr_begin(wr_begin), .wr_commit(wr_commit), .hs_active(hs_active),
    .commit_ok(commit_ok), .direct_en(direct_en), .xfer_en(xfer_en),
    .zero_en(zero_en), .clr_mode(clr_mode), .hs_exit(hs_exit));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic sel;
    assign sel = commit_ok & (wr_chan == ch[0]);
    dac2_chan #(.W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .zero_en(zero_en), .wr_en(sel), .direct_en(direct_en), .xfer_en(xfer_en),
      .wr_code(wr_code), .dac_code(code_q[ch]), .pend(pend_q[ch]));
  end

  assign dac_a = code_q[CH_A];
  assign dac_b = code_q[CH_B];
  assign pend  = pend_q;
endmodule

// File: rtl/dac2_regctl_chk.sv
module dac2_regctl_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr_fall,
  input logic         clr_lvl,
  input logic         ldac_lvl,
  input logic         commit_ok,
  input logic         hs_active,
  input logic [W-1:0] dac_a,
  input logic [W-1:0] dac_b,
  input logic [1:0]   pend,
  input logic         clr_mode,
  input logic         hs_exit
);
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> (dac_a == '0 && dac_b == '0 && pend == 2'b00 && clr_mode));

  assert_mode_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_mode) |-> $past(clr_fall));

  assert_clr_holds_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_lvl && !clr_fall) |=> ($stable(dac_a) && $stable(dac_b)));

  assert_pend_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ok && ldac_lvl) |=> (pend != 2'b00));

  assert_mode_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_mode) |-> $past(commit_ok));

  assert_hs_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hs_exit |-> $past(clr_fall && hs_active));

  assert_hs_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hs_exit |=> !hs_exit);
endmodule

bind dac2_regctl dac2_regctl_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_fall(clr_fall), .clr_lvl(clr_lvl),
  .ldac_lvl(ldac_lvl), .commit_ok(commit_ok), .hs_active(hs_active),
  .dac_a(dac_a), .dac_b(dac_b), .pend(pend), .clr_mode(clr_mode),
  .hs_exit(hs_exit));

// File: tb/dac2_regctl_tb.sv
module dac2_regctl_tb;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ldac_n_pin, clr_n_pin, wr_begin, wr_commit, wr_chan, hs_active;
  logic [15:0]  wr_data;
  logic [W-1:0] dac_a, dac_b;
  logic [1:0]   pend;
  logic         clr_mode, hs_exit;

  int n_cmp = 0;
  int n_bad = 0;
  int hs_cnt = 0;
  bit done = 1'b0;

  // bench model
  logic [W-1:0] m_in [2];
  logic [W-1:0] m_dac [2];
  logic [1:0]   m_pend;
  logic         m_mode, m_inwr, m_abort, m_ldac_low, m_clr_low;

  always #5 clk = ~clk;

  dac2_regctl #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ldac_n_pin(ldac_n_pin), .clr_n_pin(clr_n_pin),
    .wr_begin(wr_begin), .wr_commit(wr_commit), .wr_chan(wr_chan),
    .wr_data(wr_data), .hs_active(hs_active), .dac_a(dac_a), .dac_b(dac_b),
    .pend(pend), .clr_mode(clr_mode), .hs_exit(hs_exit));

  always @(negedge clk) if (rst_n && hs_exit) hs_cnt++;

  function automatic logic [W-1:0] code_of(input logic [15:0] d);
    return d[15 -: W];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    cmp({req, " dac_a"}, dac_a, m_dac[0]);
    cmp({req, " dac_b"}, dac_b, m_dac[1]);
    cmp({req, " pend"}, pend, m_pend);
    cmp({req, " clr_mode"}, clr_mode, m_mode);
  endtask

  function automatic void model_clear();
    for (int c = 0; c < 2; c++) begin
      m_in[c] = '0; m_dac[c] = '0;
    end
    m_pend  = 2'b00;
    m_mode  = 1'b1;
    m_abort = m_inwr;
  endfunction

  function automatic void model_commit(input logic ch, input logic [15:0] d);
    m_inwr = 1'b0;
    if (m_abort) begin
      m_abort = 1'b0;
      return;
    end
    m_in[ch] = code_of(d);
    m_mode   = 1'b0;
    if (m_ldac_low && !m_clr_low) begin
      m_dac[ch]  = code_of(d);
      m_pend[ch] = 1'b0;
    end else begin
      m_pend[ch] = 1'b1;
    end
  endfunction

  function automatic void model_xfer();
    if (m_clr_low) return;
    for (int c = 0; c < 2; c++)
      if (m_pend[c]) begin
        m_dac[c] = m_in[c]; m_pend[c] = 1'b0;
      end
  endfunction

  task automatic do_begin();
    wr_begin = 1'b1; tick(1); wr_begin = 1'b0; tick(1);
    m_inwr = 1'b1; m_abort = 1'b0;
  endtask

  task automatic do_commit(input logic ch, input logic [15:0] d);
    wr_chan = ch; wr_data = d; wr_commit = 1'b1; tick(1);
    wr_commit = 1'b0; tick(2);
    model_commit(ch, d);
  endtask

  task automatic clr_low();
    clr_n_pin = 1'b0; tick(4); m_clr_low = 1'b1; model_clear();
  endtask

  task automatic clr_high();
    clr_n_pin = 1'b1; tick(4); m_clr_low = 1'b0;
  endtask

  task automatic ldac_level(input logic low);
    ldac_n_pin = ~low; tick(4);
    if (low && !m_ldac_low) model_xfer();
    m_ldac_low = low;
  endtask

  task automatic ldac_pulse();
    ldac_n_pin = 1'b0; tick(3); ldac_n_pin = 1'b1; tick(4);
    model_xfer();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e));
    rst_n = 1'b0; ldac_n_pin = 1'b1; clr_n_pin = 1'b1; wr_begin = 1'b0;
    wr_commit = 1'b0; wr_chan = 1'b0; wr_data = '0; hs_active = 1'b0;
    for (int c = 0; c < 2; c++) begin m_in[c] = '0; m_dac[c] = '0; end
    m_pend = 2'b00; m_mode = 1'b0; m_inwr = 1'b0; m_abort = 1'b0;
    m_ldac_low = 1'b0; m_clr_low = 1'b0;
    tick(3); rst_n = 1'b1; tick(2);
    check_all("R1 reset");

    // R2: staged writes, low nibble must be dropped
    do_begin(); do_commit(1'b0, 16'hABCF); check_all("R2 write A");
    do_begin(); do_commit(1'b1, 16'h1237); check_all("R2 write B");
    // R3: simultaneous transfer
    ldac_pulse(); check_all("R3 both transfer");
    do_begin(); do_commit(1'b0, 16'hFFFF);
    ldac_pulse(); check_all("R3 only pending A moves");
    // R4: load pin held low
    ldac_level(1'b1);
    do_begin(); do_commit(1'b1, 16'h0000); check_all("R4 direct B");
    do_begin(); do_commit(1'b0, 16'h8001); check_all("R4 direct A");
    ldac_level(1'b0);
    // R5 / R9: clear without high-speed
    hs_cnt = 0; clr_low(); check_all("R5 clear");
    cmp("R9 no hs_exit", hs_cnt, 0);
    clr_high();
    // R8: valid write ends clear mode
    do_begin(); do_commit(1'b1, 16'h5A5A); check_all("R8 mode exit");
    // R9: clear during high speed
    hs_active = 1'b1; hs_cnt = 0; clr_low(); clr_high(); hs_active = 1'b0;
    cmp("R9 hs_exit once", hs_cnt, 1);
    check_all("R5 clear hs");
    // R7: clear in the middle of a write
    do_begin(); clr_low(); clr_high();
    do_commit(1'b0, 16'hC3C3); check_all("R7 aborted commit");
    ldac_pulse(); check_all("R7 nothing staged");
    // R6: clear held low blocks load and direct path
    do_begin(); do_commit(1'b0, 16'h7770); ldac_pulse();
    do_begin(); do_commit(1'b1, 16'h4440);
    clr_low();
    do_begin(); do_commit(1'b0, 16'h9990);
    ldac_pulse(); check_all("R6 pulse ignored");
    ldac_level(1'b1);
    do_begin(); do_commit(1'b1, 16'h2220); check_all("R6 direct ignored");
    ldac_level(1'b0);
    clr_high();
    ldac_pulse(); check_all("R6 staged writes land later");

    // random mix
    for (int i = 0; i < 200; i++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0, 1: begin
          do_begin(); do_commit(1'($urandom_range(0, 1)), 16'($urandom));
          check_all("R2/R4 random write");
        end
        2: if (!m_ldac_low) begin ldac_pulse(); check_all("R3 random pulse"); end
        3: begin ldac_level(!m_ldac_low); check_all("R4 random level"); end
        4: begin
          hs_active = 1'($urandom_range(0, 1)); hs_cnt = 0;
          clr_low(); check_all("R5 random clear");
          cmp("R9 random hs", hs_cnt, int'(hs_active));
          clr_high(); hs_active = 1'b0;
        end
        default: begin
          do_begin(); clr_low(); clr_high();
          do_commit(1'($urandom_range(0, 1)), 16'($urandom));
          check_all("R7 random abort");
        end
      endcase
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule